// File: doc/BRIEF.md
# Register-to-Register ALU with Signed-Amount Shift

This block executes the register-to-register instructions of a small 32-bit teaching processor. The fetch and decode logic ahead of it hands over the opcode nibble, the second nibble and the trailing byte of a two-byte instruction. It also supplies the current values of the two named registers. One clock later, the block presents a write-back request for the register file, or it raises an illegal-instruction flag instead.

Opcode 6 is a family of register operations. The second nibble picks the operation, the third nibble names the source register s, and the fourth nibble names the destination register d. The operations are move, add, AND, increment by one, increment by four, decrement by one, decrement by four, and bitwise NOT. Opcode 7 is a single shift instruction. Its second nibble names d, and its trailing byte is a two's-complement shift amount. A positive amount shifts left, and a negative amount shifts right by its magnitude. Other opcodes belong to other units and are ignored here.

Control is a three-state machine. **S_IDLE** means no result is pending. **S_WRITE** means a write-back is presented. **S_TRAP** means an illegal sub-opcode is flagged. On every clock edge the machine chooses its next state from the current issue alone:
- a legal opcode-6 or opcode-7 issue enters S_WRITE;
- an opcode-6 issue with the top bit of the second nibble set enters S_TRAP;
- any other cycle enters S_IDLE.

All three states follow these same transition rules.

Top module: `reg_alu_core`

## Requirements
- R1: After reset, `wr_en` and `illegal_op` are both 0.
- R2: Issuing opcode 6 with second nibble 0 makes `wr_en`=1 in the following cycle, with `wr_data` equal to `src_val` and `wr_idx` equal to the low 3 bits of the fourth nibble (`ins_b2[3:0]`).
- R3: Second nibble 1 yields `dst_val + src_val`, wrapping modulo 2^32 with no flag. Second nibble 2 yields `dst_val & src_val`.
- R4: Second nibble 3 yields `dst_val + 1`, and second nibble 4 yields `dst_val + 4`, both wrapping.
- R5: Second nibble 5 yields `dst_val - 1`, and second nibble 6 yields `dst_val - 4`, both wrapping.
- R6: Second nibble 7 yields `~dst_val`.
- R7: Opcode 7 writes to the register named by the low 3 bits of `ins_b1`. When `ins_b2`, read as a signed byte, is in 0..31, the result is `dst_val` shifted left by that amount with zero fill. An amount of 0 leaves the value unchanged.
- R8: When the signed byte is in -31..-1, the result is `dst_val` shifted right arithmetically by its magnitude, replicating bit 31.
- R9: A left amount of 32 or more gives 0. A right magnitude of 32 or more, up to 128, gives 32 copies of bit 31.
- R10: Opcode 6 with second nibble 8..15 raises `illegal_op` for one cycle and leaves `wr_en` at 0.
- R11: Any opcode other than 6 or 7 raises neither `wr_en` nor `illegal_op`.
- R12: `wr_en` and `illegal_op` last exactly one cycle for each issue, are never high together, and are 0 in the cycle after a cycle with no issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction fields and register values are valid this cycle |
| ins_op | input | 4 | Opcode nibble |
| ins_b1 | input | 4 | Second nibble: operation select for opcode 6, destination for opcode 7 |
| ins_b2 | input | 8 | Trailing byte: {s, d} for opcode 6, signed shift amount for opcode 7 |
| src_val | input | 32 | Current value of register s |
| dst_val | input | 32 | Current value of register d |
| wr_en | output | 1 | Write-back request, one cycle |
| wr_idx | output | 3 | Destination register index |
| wr_data | output | 32 | Value to write |
| illegal_op | output | 1 | Illegal register sub-opcode, one cycle |

## Verification
On every cycle, the assertions check several properties. Write and trap are mutually exclusive. Both outputs stay silent after an idle cycle and after a foreign opcode. Sub-opcodes 8..15 always trap. The move, NOT and zero-amount shift results match the inputs of the previous cycle, and so does the destination index.

The arithmetic wrap points of add, increment and decrement can only be shown by the bench's directed scenarios. The same holds for the arithmetic fill of a right shift, the saturation at 32 and at -128, and decoding 0xF8 as a right shift by 8.

// File: rtl/ralu_pkg.sv
package ralu_pkg;

    localparam logic [3:0] OP_REGOP = 4'h6;
    localparam logic [3:0] OP_SHIFT = 4'h7;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WRITE,
        S_TRAP
    } ralu_state_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_REG,
        K_SHIFT,
        K_BAD
    } ralu_kind_e;

    typedef enum logic [2:0] {
        F_MOV  = 3'd0,
        F_ADD  = 3'd1,
        F_AND  = 3'd2,
        F_INC  = 3'd3,
        F_INCA = 3'd4,
        F_DEC  = 3'd5,
        F_DECA = 3'd6,
        F_NOT  = 3'd7
    } ralu_fn_e;

endpackage

// File: rtl/ralu_decode.sv
module ralu_decode
    import ralu_pkg::*;
#(
    parameter int RIW = 3
) (
    input  logic [3:0]     op,
    input  logic [3:0]     b1,
    input  logic [7:0]     b2,
    output ralu_kind_e     kind,
    output ralu_fn_e       fn,
    output logic [RIW-1:0] dst_idx
);

    always_comb begin
        kind    = K_NONE;
        fn      = ralu_fn_e'(b1[2:0]);
        dst_idx = b2[RIW-1:0];
        if (op == OP_REGOP) begin
            kind = b1[3] ? K_BAD : K_REG;
        end else if (op == OP_SHIFT) begin
            kind    = K_SHIFT;
            dst_idx = b1[RIW-1:0];
        end
    end

endmodule

// File: rtl/ralu_logic.sv
module ralu_logic
    import ralu_pkg::*;
#(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input  ralu_fn_e       fn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   d,
    output logic [W-1:0]   y
);

    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] WORD = W'(STEP);

    always_comb begin
        unique case (fn)
            F_MOV:  y = a;
            F_ADD:  y = d + a;
            F_AND:  y = d & a;
            F_INC:  y = d + ONE;
            F_INCA: y = d + WORD;
            F_DEC:  y = d - ONE;
            F_DECA: y = d - WORD;
            F_NOT:  y = ~d;
            default: y = d;
        endcase
    end

endmodule

// File: rtl/ralu_shifter.sv
module ralu_shifter #(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic [W-1:0]  val,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  y
);

    localparam logic [AW-1:0] ONE_A = {{(AW-1){1'b0}}, 1'b1};

    logic          go_right;
    logic [AW-1:0] mag;
    logic          too_far;

    always_comb begin
        go_right = amt[AW-1];
        mag      = go_right ? (~amt + ONE_A) : amt;
        too_far  = (int'(mag) >= W);
        if (go_right) begin
            if (too_far) y = {W{val[W-1]}};
            else         y = W'($signed(val) >>> mag);
        end else begin
            if (too_far) y = '0;
            else         y = val << mag;
        end
    end

endmodule

// File: rtl/reg_alu_core.sv
module reg_alu_core
    import ralu_pkg::*;
#(
    parameter int W     = 32,
    parameter int NREGS = 8,
    parameter int STEP  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     issue_valid,
    input  logic [3:0]               ins_op,
    input  logic [3:0]               ins_b1,
    input  logic [7:0]               ins_b2,
    input  logic [W-1:0]             src_val,
    input  logic [W-1:0]             dst_val,
    output logic                     wr_en,
    output logic [$clog2(NREGS)-1:0] wr_idx,
    output logic [W-1:0]             wr_data,
    output logic                     illegal_op
);

    localparam int RIW = $clog2(NREGS);

    ralu_state_e    state, state_nx;
    ralu_kind_e     kind;
    ralu_fn_e       fn;
    logic [RIW-1:0] dst_idx;
    logic [W-1:0]   log_y, shf_y, res;

    ralu_decode #(.RIW(RIW)) u_dec (
        .op      (ins_op),
        .b1      (ins_b1),
        .b2      (ins_b2),
        .kind    (kind),
        .fn      (fn),
        .dst_idx (dst_idx)
    );

    ralu_logic #(.W(W), .STEP(STEP)) u_log (
        .fn (fn),
        .a  (src_val),
        .d  (dst_val),
        .y  (log_y)
    );

    ralu_shifter #(.W(W), .AW(8)) u_shf (
        .val (dst_val),
        .amt (ins_b2),
        .y   (shf_y)
    );

    assign res = (kind == K_SHIFT) ? shf_y : log_y;

    always_comb begin
        state_nx = S_IDLE;
        if (issue_valid) begin
            unique case (kind)
                K_REG, K_SHIFT: state_nx = S_WRITE;
                K_BAD:          state_nx = S_TRAP;
                default:        state_nx = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx  <= '0;
            wr_data <= '0;
        end else if (state_nx == S_WRITE) begin
            wr_idx  <= dst_idx;
            wr_data <= res;
        end
    end

    always_comb begin
        wr_en      = 1'b0;
        illegal_op = 1'b0;
        unique case (state)
            S_WRITE: wr_en      = 1'b1;
            S_TRAP:  illegal_op = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/ralu_chk.sv
module ralu_chk #(
    parameter int W     = 32,
    parameter int NREGS = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     issue_valid,
    input logic [3:0]               ins_op,
    input logic [3:0]               ins_b1,
    input logic [7:0]               ins_b2,
    input logic [W-1:0]             src_val,
    input logic [W-1:0]             dst_val,
    input logic                     wr_en,
    input logic [$clog2(NREGS)-1:0] wr_idx,
    input logic [W-1:0]             wr_data,
    input logic                     illegal_op
);

    localparam int RIW = $clog2(NREGS);

    a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && illegal_op));

    a_r12_quiet_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> (!wr_en && !illegal_op));

    a_r10_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && ins_op == 4'h6 && ins_b1[3]) |=> (illegal_op && !wr_en));

    a_r11_foreign: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && ins_op != 4'h6 && ins_op != 4'h7) |=> (!wr_en && !illegal_op));

    a_r2_move: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && ins_op == 4'h6 && ins_b1 == 4'h0)
        |=> (wr_en && wr_data == $past(src_val) && wr_idx == $past(ins_b2[RIW-1:0])));

    a_r6_not: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && ins_op == 4'h6 && ins_b1 == 4'h7)
        |=> (wr_en && wr_data == ~$past(dst_val)));

    a_r7_zero_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && ins_op == 4'h7 && ins_b2 == 8'h00)
        |=> (wr_en && wr_data == $past(dst_val) && wr_idx == $past(ins_b1[RIW-1:0])));

endmodule

bind reg_alu_core ralu_chk #(.W(W), .NREGS(NREGS)) u_chk (.*);

// File: tb/tb_reg_alu_core.sv
module tb_reg_alu_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic [3:0]  ins_op = '0;
    logic [3:0]  ins_b1 = '0;
    logic [7:0]  ins_b2 = '0;
    logic [31:0] src_val = '0;
    logic [31:0] dst_val = '0;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [31:0] wr_data;
    logic        illegal_op;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    reg_alu_core dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .ins_op(ins_op), .ins_b1(ins_b1), .ins_b2(ins_b2),
        .src_val(src_val), .dst_val(dst_val),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .illegal_op(illegal_op)
    );

    task automatic check(input string tag, input logic en, input logic ill,
                         input logic [2:0] idx, input logic [31:0] data);
        checks++;
        if (wr_en !== en || illegal_op !== ill ||
            (en && (wr_idx !== idx || wr_data !== data))) begin
            errors++;
            $display("FAIL %s: got en=%b ill=%b idx=%0d data=%h, exp en=%b ill=%b idx=%0d data=%h",
                     tag, wr_en, illegal_op, wr_idx, wr_data, en, ill, idx, data);
        end
    endtask

    // Issue one instruction at a falling edge; outputs are sampled one cycle later.
    task automatic issue(input logic [3:0] op, input logic [3:0] b1, input logic [7:0] b2,
                         input logic [31:0] s, input logic [31:0] d);
        @(negedge clk);
        issue_valid = 1'b1; ins_op = op; ins_b1 = b1; ins_b2 = b2;
        src_val = s; dst_val = d;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset", 1'b0, 1'b0, 3'd0, 32'h0);
    endtask

    task automatic t_move();
        issue(4'h6, 4'h0, 8'h35, 32'hCAFE_0123, 32'h1111_1111);
        check("R2 move", 1'b1, 1'b0, 3'd5, 32'hCAFE_0123);
    endtask

    task automatic t_add_and();
        issue(4'h6, 4'h1, 8'h12, 32'h0000_0002, 32'hFFFF_FFFF);
        check("R3 add wrap", 1'b1, 1'b0, 3'd2, 32'h0000_0001);
        issue(4'h6, 4'h2, 8'h07, 32'hF0F0_1234, 32'h0FF0_FF00);
        check("R3 and", 1'b1, 1'b0, 3'd7, 32'h00F0_1200);
    endtask

    task automatic t_inc();
        issue(4'h6, 4'h3, 8'h01, 32'h0, 32'h0000_0009);
        check("R4 inc", 1'b1, 1'b0, 3'd1, 32'h0000_000A);
        issue(4'h6, 4'h4, 8'h03, 32'h0, 32'hFFFF_FFFE);
        check("R4 inca wrap", 1'b1, 1'b0, 3'd3, 32'h0000_0002);
    endtask

    task automatic t_dec();
        issue(4'h6, 4'h5, 8'h04, 32'h0, 32'h0000_0000);
        check("R5 dec wrap", 1'b1, 1'b0, 3'd4, 32'hFFFF_FFFF);
        issue(4'h6, 4'h6, 8'h06, 32'h0, 32'h0000_2000);
        check("R5 deca", 1'b1, 1'b0, 3'd6, 32'h0000_1FFC);
    endtask

    task automatic t_not();
        issue(4'h6, 4'h7, 8'h00, 32'h0, 32'h1234_5678);
        check("R6 not", 1'b1, 1'b0, 3'd0, 32'hEDCB_A987);
    endtask

    task automatic t_shift_left();
        issue(4'h7, 4'h5, 8'h04, 32'h0, 32'h8000_00F1);
        check("R7 shl 4", 1'b1, 1'b0, 3'd5, 32'h0000_0F10);
        issue(4'h7, 4'h2, 8'h00, 32'h0, 32'hDEAD_BEEF);
        check("R7 shift 0", 1'b1, 1'b0, 3'd2, 32'hDEAD_BEEF);
        issue(4'h7, 4'h1, 8'h1F, 32'h0, 32'h0000_0003);
        check("R7 shl 31", 1'b1, 1'b0, 3'd1, 32'h8000_0000);
    endtask

    task automatic t_shift_right();
        issue(4'h7, 4'h5, 8'hF8, 32'h0, 32'h8000_0000);
        check("R8 sar 8 neg", 1'b1, 1'b0, 3'd5, 32'hFF80_0000);
        issue(4'h7, 4'h6, 8'hFF, 32'h0, 32'h4000_0010);
        check("R8 sar 1 pos", 1'b1, 1'b0, 3'd6, 32'h2000_0008);
    endtask

    task automatic t_saturate();
        issue(4'h7, 4'h3, 8'h20, 32'h0, 32'hFFFF_FFFF);
        check("R9 shl 32", 1'b1, 1'b0, 3'd3, 32'h0);
        issue(4'h7, 4'h3, 8'h80, 32'h0, 32'h8000_0001);
        check("R9 sar 128 neg", 1'b1, 1'b0, 3'd3, 32'hFFFF_FFFF);
        issue(4'h7, 4'h4, 8'hE0, 32'h0, 32'h7FFF_FFFF);
        check("R9 sar 32 pos", 1'b1, 1'b0, 3'd4, 32'h0);
    endtask

    task automatic t_illegal();
        issue(4'h6, 4'h8, 8'h12, 32'h5, 32'h6);
        check("R10 sub 8", 1'b0, 1'b1, 3'd0, 32'h0);
        issue(4'h6, 4'hF, 8'h12, 32'h5, 32'h6);
        check("R10 sub F", 1'b0, 1'b1, 3'd0, 32'h0);
    endtask

    task automatic t_foreign();
        issue(4'h1, 4'h0, 8'h12, 32'h5, 32'h6);
        check("R11 op 1", 1'b0, 1'b0, 3'd0, 32'h0);
        issue(4'hF, 4'h0, 8'h00, 32'h5, 32'h6);
        check("R11 op F", 1'b0, 1'b0, 3'd0, 32'h0);
    endtask

    task automatic t_pulse();
        issue(4'h6, 4'h3, 8'h02, 32'h0, 32'h0000_0010);
        check("R12 pulse", 1'b1, 1'b0, 3'd2, 32'h0000_0011);
        @(negedge clk);
        check("R12 one cycle", 1'b0, 1'b0, 3'd0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_move();
        t_add_and();
        t_inc();
        t_dec();
        t_not();
        t_shift_left();
        t_shift_right();
        t_saturate();
        t_illegal();
        t_foreign();
        t_pulse();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule